// File: doc/BRIEF.md
# Dual-Driver GPIO Port with Pull-ups

This block is a general-purpose I/O port of `PINS` lines (16 by default) behind a small synchronous register bus. A packed control word gives every pin two bits: one turns on the CPU's output driver and one turns on a weak pull-up. A CPU data latch holds the values the CPU drives. An on-chip peripheral can also drive the same pins through its own direction and data vectors. The block combines these three sources into one resolved value per line. It returns the resolved lines when the data register is read, and it also presents them on a port.

Each time the resolved lines move, the block forms a change vector. The cause can be a register write or a change on the peripheral inputs. Up to `CLIENTS` client slots each supply a trigger mask. A client receives a one-cycle notification strobe when its slot is enabled and its mask overlaps the change vector. Clients use the strobe to react to pin activity they care about and ignore the rest.

Top module: `gpio_dual_port`

## Requirements
- R1: After reset, the control word, the CPU data latch, the client enable register and the sampled peripheral vectors are zero. With the peripheral idle, `lines_o`, `notify_o` and `bus_rdata_o` are all zero.
- R2: The control register is at byte offset 0x0. For pin n, control bit 2n enables the CPU driver and bit 2n+1 enables the pull-up. A read returns the stored word.
- R3: Each resolved line equals (cpu_dir AND cpu_data) OR (periph_dir AND periph_data) OR (NOT(cpu_dir OR periph_dir) AND pullup). When both drivers are enabled on a pin, a 1 from either driver wins.
- R4: A read of the data register at offset 0x4 returns the resolved lines in bits [PINS-1:0], with zeros above them. It never returns the stored CPU latch, so latch bits on undriven pins are invisible.
- R5: A register write sampled at clock edge k updates `lines_o` after edge k. The resulting notification is high for the one cycle that follows edge k+1.
- R6: When the resolved lines before and after an update are equal, no client is notified.
- R7: Client c is notified only if bits [c*PINS +: PINS] of `client_mask_i`, ANDed with the change vector, are nonzero.
- R8: The client enable register is at offset 0x8, with bit c enabling client c. A disabled client is never notified, and the register reads back its stored value.
- R9: The peripheral direction and data inputs are sampled on each clock edge. A change sampled at edge k moves `lines_o` after edge k and notifies after edge k+1, with the same timing as a write.
- R10: Reads of any offset other than 0x0, 0x4 and 0x8 return zero. Writes to such offsets change no register and cause no notification.
- R11: Byte enable bit b gates write data bits [8b+7:8b] for every register. Bytes whose enable is low keep their value.
- R12: Read data appears on `bus_rdata_o` one cycle after the address is sampled. It reflects the state before any write taken at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_we_i | input | 1 | Write enable |
| bus_be_i | input | 4 | Byte enables for a write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| periph_dir_i | input | PINS | Peripheral driver enables, one bit per pin |
| periph_data_i | input | PINS | Peripheral drive values |
| client_mask_i | input | CLIENTS*PINS | Trigger mask for each client, PINS bits per client |
| notify_o | output | CLIENTS | Per-client change notification strobes |
| lines_o | output | PINS | Resolved line values |

## Verification
Every result has a fixed delay from its cause, counted in rising edges. `lines_o` follows one edge after the write or the peripheral sample that changes it. `notify_o` rises one edge after that and lasts one cycle. `bus_rdata_o` follows one edge after the address. The bench drives inputs on falling edges and keeps a behavioural model that steps on each rising edge. It compares the model with all three outputs on the next falling edge, so each value is observed in the exact cycle it is due. The directed checks follow the same count: a notification is sampled at the second falling edge after a write is taken, and a peripheral change is checked on `lines_o` at the first falling edge and on `notify_o` at the second.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
   localparam int BUS_W   = 32;
   localparam int BE_W    = BUS_W / 8;
   localparam int OFF_CTL = 0;
   localparam int OFF_DAT = 4;
   localparam int OFF_ENA = 8;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTL  = 2'd1,
      SEL_DAT  = 2'd2,
      SEL_ENA  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_dual_pkg::*;
#(
   parameter int PINS    = 16,
   parameter int CLIENTS = 4,
   parameter int ADDR_W  = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               we_i,
   input  logic [BE_W-1:0]    be_i,
   input  logic [BUS_W-1:0]   wdata_i,
   input  logic [PINS-1:0]    lines_i,
   output logic [PINS-1:0]    dir_o,
   output logic [PINS-1:0]    pull_o,
   output logic [PINS-1:0]    data_o,
   output logic [CLIENTS-1:0] en_o,
   output logic [BUS_W-1:0]   rdata_o
);
   localparam int CTL_W = 2 * PINS;

   if (CTL_W > BUS_W) begin : g_bad_pins
      $error("gpio_regs: 2*PINS must fit the bus width");
   end
   if (CLIENTS > BUS_W) begin : g_bad_clients
      $error("gpio_regs: CLIENTS must fit the bus width");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("gpio_regs: ADDR_W too small for the register map");
   end

   logic [CTL_W-1:0]   ctl_q;
   logic [PINS-1:0]    dat_q;
   logic [CLIENTS-1:0] en_q;
   logic [BUS_W-1:0]   rd_mux;
   logic [BUS_W-1:0]   rdata_q;
   reg_sel_e           sel;

   always_comb begin
      if (addr_i == ADDR_W'(OFF_CTL))      sel = SEL_CTL;
      else if (addr_i == ADDR_W'(OFF_DAT)) sel = SEL_DAT;
      else if (addr_i == ADDR_W'(OFF_ENA)) sel = SEL_ENA;
      else                                 sel = SEL_NONE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctl_q <= '0;
      end else if (we_i && sel == SEL_CTL) begin
         for (int i = 0; i < CTL_W; i++)
            if (be_i[i/8]) ctl_q[i] <= wdata_i[i];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dat_q <= '0;
      end else if (we_i && sel == SEL_DAT) begin
         for (int i = 0; i < PINS; i++)
            if (be_i[i/8]) dat_q[i] <= wdata_i[i];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= '0;
      end else if (we_i && sel == SEL_ENA) begin
         for (int i = 0; i < CLIENTS; i++)
            if (be_i[i/8]) en_q[i] <= wdata_i[i];
      end
   end

   for (genvar n = 0; n < PINS; n++) begin : g_unpack
      assign dir_o[n]  = ctl_q[2*n];
      assign pull_o[n] = ctl_q[2*n+1];
   end

   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_CTL: rd_mux[CTL_W-1:0]   = ctl_q;
         SEL_DAT: rd_mux[PINS-1:0]    = lines_i;
         SEL_ENA: rd_mux[CLIENTS-1:0] = en_q;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rdata_q <= '0;
      else         rdata_q <= rd_mux;
   end

   assign data_o  = dat_q;
   assign en_o    = en_q;
   assign rdata_o = rdata_q;

   // R10: an unmapped address yields zero on the next cycle
   a_r10_unmapped_reads_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(sel == SEL_NONE) |-> rdata_o == '0);
endmodule

// File: rtl/gpio_resolve.sv
module gpio_resolve #(
   parameter int PINS = 16
) (
   input  logic [PINS-1:0] cpu_dir_i,
   input  logic [PINS-1:0] cpu_pull_i,
   input  logic [PINS-1:0] cpu_data_i,
   input  logic [PINS-1:0] per_dir_i,
   input  logic [PINS-1:0] per_data_i,
   output logic [PINS-1:0] lines_o
);
   if (PINS < 1) begin : g_bad_pins
      $error("gpio_resolve: PINS must be positive");
   end

   for (genvar n = 0; n < PINS; n++) begin : g_pin
      logic by_cpu, by_per, by_pull;
      assign by_cpu  = cpu_dir_i[n] & cpu_data_i[n];
      assign by_per  = per_dir_i[n] & per_data_i[n];
      assign by_pull = ~(cpu_dir_i[n] | per_dir_i[n]) & cpu_pull_i[n];
      assign lines_o[n] = by_cpu | by_per | by_pull;
   end
endmodule

// File: rtl/gpio_notify.sv
module gpio_notify #(
   parameter int PINS    = 16,
   parameter int CLIENTS = 4
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [PINS-1:0]         lines_i,
   input  logic [CLIENTS*PINS-1:0] mask_i,
   input  logic [CLIENTS-1:0]      en_i,
   output logic [CLIENTS-1:0]      notify_o
);
   if (CLIENTS < 1) begin : g_bad_clients
      $error("gpio_notify: CLIENTS must be positive");
   end

   logic [PINS-1:0]    lines_q;
   logic [PINS-1:0]    chg;
   logic [CLIENTS-1:0] hit;
   logic [CLIENTS-1:0] notify_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lines_q <= '0;
      else         lines_q <= lines_i;
   end

   assign chg = lines_i ^ lines_q;

   for (genvar c = 0; c < CLIENTS; c++) begin : g_client
      assign hit[c] = en_i[c] & (|(mask_i[c*PINS +: PINS] & chg));

      // R7: a strobe needs an overlap of the mask with the change
      a_r7_mask_overlap : assert property (@(posedge clk_i) disable iff (!rst_ni)
         notify_o[c] |-> (|($past(mask_i[c*PINS +: PINS]) &
                           ($past(lines_i) ^ $past(lines_i, 2)))));

      // R8: a disabled slot stays silent
      a_r8_enabled_only : assert property (@(posedge clk_i) disable iff (!rst_ni)
         notify_o[c] |-> $past(en_i[c]));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) notify_q <= '0;
      else         notify_q <= hit;
   end

   assign notify_o = notify_q;

   // R6: no strobe unless the lines actually moved
   a_r6_needs_change : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|notify_o) |-> $past(lines_i) != $past(lines_i, 2));
endmodule

// File: rtl/gpio_dual_port.sv
module gpio_dual_port
   import gpio_dual_pkg::*;
#(
   parameter int PINS    = 16,
   parameter int CLIENTS = 4,
   parameter int ADDR_W  = 4
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [ADDR_W-1:0]       bus_addr_i,
   input  logic                    bus_we_i,
   input  logic [3:0]              bus_be_i,
   input  logic [31:0]             bus_wdata_i,
   output logic [31:0]             bus_rdata_o,
   input  logic [PINS-1:0]         periph_dir_i,
   input  logic [PINS-1:0]         periph_data_i,
   input  logic [CLIENTS*PINS-1:0] client_mask_i,
   output logic [CLIENTS-1:0]      notify_o,
   output logic [PINS-1:0]         lines_o
);
   localparam int MASK_W = CLIENTS * PINS;

   if (BUS_W != 32 || MASK_W < 1) begin : g_bad_cfg
      $error("gpio_dual_port: unsupported configuration");
   end

   logic [PINS-1:0]    per_dir_q, per_dat_q;
   logic [PINS-1:0]    cpu_dir, cpu_pull, cpu_dat;
   logic [PINS-1:0]    lines;
   logic [CLIENTS-1:0] en;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         per_dir_q <= '0;
         per_dat_q <= '0;
      end else begin
         per_dir_q <= periph_dir_i;
         per_dat_q <= periph_data_i;
      end
   end

   gpio_regs #(.PINS(PINS), .CLIENTS(CLIENTS), .ADDR_W(ADDR_W)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (bus_addr_i),
      .we_i    (bus_we_i),
      .be_i    (bus_be_i),
      .wdata_i (bus_wdata_i),
      .lines_i (lines),
      .dir_o   (cpu_dir),
      .pull_o  (cpu_pull),
      .data_o  (cpu_dat),
      .en_o    (en),
      .rdata_o (bus_rdata_o)
   );

   gpio_resolve #(.PINS(PINS)) u_resolve (
      .cpu_dir_i  (cpu_dir),
      .cpu_pull_i (cpu_pull),
      .cpu_data_i (cpu_dat),
      .per_dir_i  (per_dir_q),
      .per_data_i (per_dat_q),
      .lines_o    (lines)
   );

   gpio_notify #(.PINS(PINS), .CLIENTS(CLIENTS)) u_notify (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lines_i  (lines),
      .mask_i   (client_mask_i),
      .en_i     (en),
      .notify_o (notify_o)
   );

   assign lines_o = lines;

   // R9: a peripheral driving a 1 on a pin forces that line high next cycle
   a_r9_periph_drives_high : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(|(periph_dir_i & periph_data_i)) |->
         ((lines_o & $past(periph_dir_i & periph_data_i)) == $past(periph_dir_i & periph_data_i)));
endmodule

// File: tb/gpio_dual_port_bench.sv
module gpio_dual_port_bench;
   localparam int PINS = 16;
   localparam int CL   = 4;
   localparam int AW   = 4;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [AW-1:0]     addr;
   logic              we;
   logic [3:0]        be;
   logic [31:0]       wdata;
   logic [31:0]       rdata;
   logic [PINS-1:0]   pdir, pdat;
   logic [CL*PINS-1:0] mask;
   logic [CL-1:0]     notify;
   logic [PINS-1:0]   lines;

   always #4 clk = ~clk;

   gpio_dual_port #(.PINS(PINS), .CLIENTS(CL), .ADDR_W(AW)) u_gpio_dual_port (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
      .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .periph_dir_i(pdir), .periph_data_i(pdat), .client_mask_i(mask),
      .notify_o(notify), .lines_o(lines));

   int total = 0;
   int bad   = 0;
   bit cmp_on = 1'b0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // behavioural reference model
   logic [31:0]     m_ctl;
   logic [PINS-1:0] m_dat, m_pdir, m_pdat, m_prev;
   logic [CL-1:0]   m_en, e_notify;
   logic [31:0]     e_rdata;

   function automatic logic [PINS-1:0] model_lines();
      logic [PINS-1:0] r;
      for (int n = 0; n < PINS; n++) begin
         bit d  = m_ctl[2*n];
         bit pu = m_ctl[2*n+1];
         if (d && m_dat[n])                r[n] = 1'b1;
         else if (m_pdir[n] && m_pdat[n])  r[n] = 1'b1;
         else if (!d && !m_pdir[n] && pu)  r[n] = 1'b1;
         else                              r[n] = 1'b0;
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctl = '0; m_dat = '0; m_en = '0; m_pdir = '0; m_pdat = '0;
         m_prev = '0; e_notify = '0; e_rdata = '0;
      end else begin
         logic [PINS-1:0] cur;
         cur = model_lines();
         for (int c = 0; c < CL; c++)
            e_notify[c] = m_en[c] && ((mask[c*PINS +: PINS] & (cur ^ m_prev)) != 0);
         m_prev = cur;
         case (addr)
            4'h0:    e_rdata = m_ctl;
            4'h4:    e_rdata = {16'h0, cur};
            4'h8:    e_rdata = {28'h0, m_en};
            default: e_rdata = '0;
         endcase
         if (we) begin
            for (int b = 0; b < 4; b++) begin
               if (be[b]) begin
                  if (addr == 4'h0) m_ctl[8*b +: 8] = wdata[8*b +: 8];
                  if (addr == 4'h4 && b < 2) m_dat[8*b +: 8] = wdata[8*b +: 8];
                  if (addr == 4'h8 && b == 0) m_en = wdata[3:0];
               end
            end
         end
         m_pdir = pdir;
         m_pdat = pdat;
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R3 lines model", {16'h0, lines}, {16'h0, model_lines()});
         chk("R12 rdata model", rdata, e_rdata);
         chk("R5 notify model", {28'h0, notify}, {28'h0, e_notify});
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
      addr = a; wdata = d; be = b; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      addr = a; we = 1'b0;
      @(negedge clk);
      d = rdata;
   endtask

   initial begin
      logic [31:0] v;
      rst_n = 1'b0; addr = '0; we = 1'b0; be = '0; wdata = '0;
      pdir = '0; pdat = '0;
      mask = {16'hFFFF, 16'hFF00, 16'h00FF, 16'hFFFF};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      // R1 reset state
      chk("R1 lines", {16'h0, lines}, 32'h0);
      chk("R1 notify", {28'h0, notify}, 32'h0);
      chk("R1 rdata", rdata, 32'h0);
      rd(4'h0, v); chk("R1 ctl zero", v, 32'h0);

      wr(4'h8, 32'hF, 4'hF);
      rd(4'h8, v); chk("R8 enable readback", v, 32'hF);
      // R2 encoding: pins 0,1 outputs
      wr(4'h0, 32'h0000_0005, 4'hF);
      rd(4'h0, v); chk("R2 ctl readback", v, 32'h5);
      wr(4'h4, 32'h0003, 4'hF);
      @(negedge clk);
      chk("R7 notify mask filter", {28'h0, notify}, 32'hB);
      rd(4'h4, v); chk("R4 data read resolved", v, 32'h3);
      // R6 same value again
      wr(4'h4, 32'h0003, 4'hF);
      @(negedge clk);
      chk("R6 no change no notify", {28'h0, notify}, 32'h0);
      // R4 latch bits on undriven pins are invisible
      wr(4'h4, 32'hFFFF_FFFF, 4'hF);
      @(negedge clk);
      chk("R6 undriven latch no notify", {28'h0, notify}, 32'h0);
      rd(4'h4, v); chk("R4 latch not returned", v, 32'h3);
      // R2 pull-ups on pins 4 and 5
      wr(4'h0, 32'h0000_0A05, 4'hF);
      chk("R2 pullup lines", {16'h0, lines}, 32'h33);
      @(negedge clk);
      chk("R5 notify timing", {28'h0, notify}, 32'hB);
      @(negedge clk);
      chk("R5 single pulse", {28'h0, notify}, 32'h0);
      // R11 top byte only
      wr(4'h0, 32'hFFFF_FFFF, 4'b1000);
      @(negedge clk);
      chk("R11 notify high pins", {28'h0, notify}, 32'hD);
      rd(4'h0, v); chk("R11 byte enable ctl", v, 32'hFF00_0A05);
      chk("R11 lines", {16'h0, lines}, 32'hF033);
      // R9 peripheral drives pin 8
      pdir = 16'h0100; pdat = 16'h0100;
      @(negedge clk);
      chk("R9 lines after sample", {16'h0, lines}, 32'hF133);
      chk("R9 no early notify", {28'h0, notify}, 32'h0);
      @(negedge clk);
      chk("R9 notify", {28'h0, notify}, 32'hD);
      // R3 both drive pin 0, a 1 wins
      pdir = 16'h0101; pdat = 16'h0100;
      @(negedge clk);
      chk("R3 one wins", {16'h0, lines}, 32'hF133);
      @(negedge clk);
      chk("R3 no notify", {28'h0, notify}, 32'h0);
      // R8 disable client 3
      wr(4'h8, 32'h7, 4'hF);
      wr(4'h4, 32'hFFFE, 4'hF);
      chk("R3 both low", {16'h0, lines}, 32'hF132);
      @(negedge clk);
      chk("R8 disabled client", {28'h0, notify}, 32'h3);
      rd(4'h8, v); chk("R8 enable readback 2", v, 32'h7);
      // R10 unmapped
      rd(4'hC, v); chk("R10 unmapped read", v, 32'h0);
      wr(4'hC, 32'hFFFF_FFFF, 4'hF);
      @(negedge clk);
      chk("R10 unmapped write no notify", {28'h0, notify}, 32'h0);
      rd(4'h0, v); chk("R10 ctl untouched", v, 32'hFF00_0A05);
      rd(4'h4, v); chk("R10 data untouched", v, 32'hF132);

      // mixed traffic, compared against the model on every clock
      for (int i = 0; i < 600; i++) begin
         logic [3:0] pick;
         pick = 4'($urandom_range(0, 4));
         addr  = (pick == 4) ? 4'($urandom) : pick << 2;
         we    = 1'($urandom);
         be    = 4'($urandom);
         wdata = $urandom;
         if ($urandom_range(0, 3) == 0) begin
            pdir = 16'($urandom);
            pdat = 16'($urandom);
         end
         if ($urandom_range(0, 15) == 0) mask = {$urandom, $urandom};
         @(negedge clk);
      end
      we = 1'b0;
      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule